// File: doc/BRIEF.md
# TLB Fault Handle Controller

This block is the per-context fault handle that sits between a stalled control block and the software that services its address-translation misses. When the control block reports a TLB miss or a TLB-modify fault, the handle captures the faulting virtual address, the address-space ID, the TLB index/way and the context number. It then parks in a miss state. In fault-map mode it also raises a fault bit so that an interrupt or poller can find the context. The control block can instead report a hardware error class. In that case the handle enters an error state and flags an exception.

Software resolves the miss by presenting a fill and a 3-bit opcode. The fill holds the page frame number, the address-space ID, the virtual address, the dirty bit, the page size and the access attribute. The opcode picks one of five resolutions. Write-only drives the TLB write port once and stays in the miss. Write-and-restart writes the entry and then releases the control block. Restart-only releases the control block without a write. Exception aborts the control block. User-polling selects a mode in which misses leave the fault map alone. Commands that make no sense in the current state are refused with an exception status. The TLB array itself lives outside the block and is reached through the write port.

Top module: `tlb_fault_handle`

## Requirements
- R1: After reset the state is inactive (0), the status is idle (0), and the fault bit, write strobe, restart strobe and abort strobe are all low. A no-operation command (opcode 0) moves the inactive state to idle (1).
- R2: A fault with cause 1 (TLB miss) or 2 (TLB modify) that arrives in the idle state latches the miss address, the address-space ID, the index/way, the context number and the cause. The state becomes 3 (miss, fault-map mode) or 2 (miss, user-polling mode). Faults that arrive in any other state are ignored.
- R3: A miss taken in fault-map mode sets the fault bit, and a miss taken in user-polling mode leaves it clear. The bit clears when the miss is resolved by restart, write-and-restart or exception.
- R4: A fault with a hardware-error cause (3 to 8) taken in idle sets the state to 4 and the status to exception (1). A cause of 0 or above 8 is ignored.
- R5: Write-only (opcode 2) in a miss state raises the TLB write strobe for exactly one cycle with status active (2) and state 5. It then returns to the same miss state with status idle. The write port carries the latched fill and the captured index/way.
- R6: Write-and-restart (opcode 3) in a miss state gives one write cycle (state 5), then one restart cycle (state 6), then idle.
- R7: Restart (opcode 1) in a miss state raises the restart strobe for one cycle (state 6) and then returns to idle with the cause cleared to 0.
- R8: Restart, write-only or write-and-restart issued outside a miss state sets status to exception and leaves the state unchanged. Opcodes 5 and 6 always do the same.
- R9: Exception (opcode 4) in a miss or hardware-error state returns the handle to idle with status exception and pulses the abort strobe for one cycle. In any other state it only sets status to exception.
- R10: The handle word packs the command-busy bit at bit 0, the status at bits 17:16, the state at bits 22:20 and the cause at bits 30:24. All other bits read 0.
- R11: The TLB physical address equals the page frame number shifted left by 12, whatever the page size. The access attribute is passed through as its code: RAM 0, MMIO 1, non-coherent RAM 2, register 3.
- R12: A command presented while a write or restart sequence is in progress is ignored.
- R13: User-polling mode (opcode 7) is accepted in the idle or inactive state with status idle. In any other state it is refused with status exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_id | input | 4 | Context number of this handle |
| fault_valid | input | 1 | Control block reports a fault this cycle |
| fault_cause | input | 7 | Fault cause code |
| fault_vaddr | input | 64 | Faulting virtual address |
| fault_asid | input | 24 | Faulting address-space ID |
| fault_idxway | input | 12 | TLB index/way of the fault |
| cmd_valid | input | 1 | Software issues a command this cycle |
| cmd_opc | input | 3 | Command opcode |
| fill_pfn | input | 41 | Fill page frame number |
| fill_asid | input | 24 | Fill address-space ID |
| fill_vaddr | input | 64 | Fill virtual address |
| fill_dirty | input | 1 | Fill dirty bit |
| fill_pagesize | input | 5 | Fill page size code |
| fill_gaa | input | 2 | Fill access attribute code |
| state | output | 3 | Handle state |
| status | output | 2 | Command status |
| cause | output | 7 | Captured cause |
| miss_vaddr | output | 64 | Captured miss address |
| miss_asid | output | 24 | Captured miss address-space ID |
| miss_idxway | output | 12 | Captured index/way |
| miss_ctx | output | 4 | Captured context number |
| fault_bit | output | 1 | Fault-map bit of this context |
| hdl_word | output | 32 | Packed handle word |
| tlb_we | output | 1 | TLB write strobe |
| tlb_idxway | output | 12 | TLB write index/way |
| tlb_paddr | output | 53 | TLB physical address |
| tlb_asid | output | 24 | TLB entry address-space ID |
| tlb_vaddr | output | 64 | TLB entry virtual address |
| tlb_dirty | output | 1 | TLB entry dirty bit |
| tlb_pagesize | output | 5 | TLB entry page size |
| tlb_gaa | output | 2 | TLB entry access attribute |
| restart_cb | output | 1 | Restart strobe to the control block |
| cb_abort | output | 1 | Abort strobe to the control block |

## Verification
The assertions check several rules on every cycle. The write, restart and abort strobes last a single cycle. Active status appears only during a write or restart sequence. The fault bit is never set outside a fault-map miss and its resolution. The error state always holds a hardware-error cause. Only the bench scenarios can show the rest. These are the captured field values, the return to the originating miss state after a write-only command, the order of the write and restart cycles, the refusal of commands that do not fit the current state or arrive while busy, and the packing of the handle word.

// File: rtl/tlb_fault_handle.sv
module tlb_fault_handle #(
  parameter int VA_W   = 64,
  parameter int ASID_W = 24,
  parameter int PFN_W  = 41,
  parameter int IDX_W  = 12,
  parameter int CTX_W  = 4,
  parameter int PG_SH  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CTX_W-1:0]       ctx_id,
  input  logic                   fault_valid,
  input  logic [6:0]             fault_cause,
  input  logic [VA_W-1:0]        fault_vaddr,
  input  logic [ASID_W-1:0]      fault_asid,
  input  logic [IDX_W-1:0]       fault_idxway,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_opc,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic [VA_W-1:0]        fill_vaddr,
  input  logic                   fill_dirty,
  input  logic [4:0]             fill_pagesize,
  input  logic [1:0]             fill_gaa,
  output logic [2:0]             state,
  output logic [1:0]             status,
  output logic [6:0]             cause,
  output logic [VA_W-1:0]        miss_vaddr,
  output logic [ASID_W-1:0]      miss_asid,
  output logic [IDX_W-1:0]       miss_idxway,
  output logic [CTX_W-1:0]       miss_ctx,
  output logic                   fault_bit,
  output logic [31:0]            hdl_word,
  output logic                   tlb_we,
  output logic [IDX_W-1:0]       tlb_idxway,
  output logic [PFN_W+PG_SH-1:0] tlb_paddr,
  output logic [ASID_W-1:0]      tlb_asid,
  output logic [VA_W-1:0]        tlb_vaddr,
  output logic                   tlb_dirty,
  output logic [4:0]             tlb_pagesize,
  output logic [1:0]             tlb_gaa,
  output logic                   restart_cb,
  output logic                   cb_abort
);

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_RST  = 3'd1;
  localparam logic [2:0] OP_WO   = 3'd2;
  localparam logic [2:0] OP_WR   = 3'd3;
  localparam logic [2:0] OP_EXC  = 3'd4;
  localparam logic [2:0] OP_POLL = 3'd7;

  localparam logic [1:0] SS_IDLE = 2'd0;
  localparam logic [1:0] SS_EXC  = 2'd1;
  localparam logic [1:0] SS_ACT  = 2'd2;

  localparam logic [2:0] S_INACT = 3'd0;
  localparam logic [2:0] S_IDLE  = 3'd1;
  localparam logic [2:0] S_UPM   = 3'd2;
  localparam logic [2:0] S_FMM   = 3'd3;
  localparam logic [2:0] S_HWE   = 3'd4;
  localparam logic [2:0] S_WRT   = 3'd5;
  localparam logic [2:0] S_RST   = 3'd6;

  logic [2:0]        state_q, back_q;
  logic [1:0]        status_q;
  logic [6:0]        cause_q;
  logic [VA_W-1:0]   vaddr_q, fvaddr_q;
  logic [ASID_W-1:0] asid_q, fasid_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CTX_W-1:0]  ctx_q;
  logic [PFN_W-1:0]  pfn_q;
  logic              poll_q, fbit_q, chain_q, abort_q, fdirty_q;
  logic [4:0]        fpg_q;
  logic [1:0]        fgaa_q;

  wire cause_miss = (fault_cause == 7'd1) || (fault_cause == 7'd2);
  wire cause_hwe  = (fault_cause >= 7'd3) && (fault_cause <= 7'd8);
  wire flt_take   = fault_valid && (state_q == S_IDLE) && (cause_miss || cause_hwe);
  wire busy       = (state_q == S_WRT) || (state_q == S_RST);
  wire in_miss    = (state_q == S_UPM) || (state_q == S_FMM);
  wire cmd_take   = cmd_valid && !busy && !flt_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_INACT;
      back_q   <= S_IDLE;
      status_q <= SS_IDLE;
      cause_q  <= '0;
      vaddr_q  <= '0;
      asid_q   <= '0;
      idx_q    <= '0;
      ctx_q    <= '0;
      poll_q   <= 1'b0;
      fbit_q   <= 1'b0;
      chain_q  <= 1'b0;
      abort_q  <= 1'b0;
      pfn_q    <= '0;
      fasid_q  <= '0;
      fvaddr_q <= '0;
      fdirty_q <= 1'b0;
      fpg_q    <= '0;
      fgaa_q   <= '0;
    end else begin
      abort_q <= 1'b0;
      if (flt_take) begin
        vaddr_q <= fault_vaddr;
        asid_q  <= fault_asid;
        idx_q   <= fault_idxway;
        ctx_q   <= ctx_id;
        cause_q <= fault_cause;
        if (cause_hwe) begin
          state_q  <= S_HWE;
          status_q <= SS_EXC;
        end else begin
          state_q  <= poll_q ? S_UPM : S_FMM;
          status_q <= SS_IDLE;
          fbit_q   <= !poll_q;
        end
      end else if (cmd_take) begin
        case (cmd_opc)
          OP_NOP: begin
            status_q <= SS_IDLE;
            if (state_q == S_INACT) state_q <= S_IDLE;
          end
          OP_RST: begin
            if (in_miss) begin
              state_q  <= S_RST;
              status_q <= SS_ACT;
            end else status_q <= SS_EXC;
          end
          OP_WO, OP_WR: begin
            if (in_miss) begin
              state_q  <= S_WRT;
              status_q <= SS_ACT;
              back_q   <= state_q;
              chain_q  <= (cmd_opc == OP_WR);
              pfn_q    <= fill_pfn;
              fasid_q  <= fill_asid;
              fvaddr_q <= fill_vaddr;
              fdirty_q <= fill_dirty;
              fpg_q    <= fill_pagesize;
              fgaa_q   <= fill_gaa;
            end else status_q <= SS_EXC;
          end
          OP_EXC: begin
            status_q <= SS_EXC;
            if (in_miss || state_q == S_HWE) begin
              state_q <= S_IDLE;
              abort_q <= 1'b1;
              fbit_q  <= 1'b0;
              cause_q <= '0;
            end
          end
          OP_POLL: begin
            if (state_q == S_IDLE || state_q == S_INACT) begin
              poll_q   <= 1'b1;
              status_q <= SS_IDLE;
            end else status_q <= SS_EXC;
          end
          default: status_q <= SS_EXC;
        endcase
      end else if (state_q == S_WRT) begin
        if (chain_q) state_q <= S_RST;
        else begin
          state_q  <= back_q;
          status_q <= SS_IDLE;
        end
      end else if (state_q == S_RST) begin
        state_q  <= S_IDLE;
        status_q <= SS_IDLE;
        fbit_q   <= 1'b0;
        cause_q  <= '0;
      end
    end
  end

  assign state        = state_q;
  assign status       = status_q;
  assign cause        = cause_q;
  assign miss_vaddr   = vaddr_q;
  assign miss_asid    = asid_q;
  assign miss_idxway  = idx_q;
  assign miss_ctx     = ctx_q;
  assign fault_bit    = fbit_q;
  assign hdl_word     = {1'b0, cause_q, 1'b0, state_q, 2'b00, status_q, 15'd0, status_q == SS_ACT};
  assign tlb_we       = (state_q == S_WRT);
  assign tlb_idxway   = idx_q;
  assign tlb_paddr    = {pfn_q, {PG_SH{1'b0}}};
  assign tlb_asid     = fasid_q;
  assign tlb_vaddr    = fvaddr_q;
  assign tlb_dirty    = fdirty_q;
  assign tlb_pagesize = fpg_q;
  assign tlb_gaa      = fgaa_q;
  assign restart_cb   = (state_q == S_RST);
  assign cb_abort     = abort_q;

  a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we |=> !tlb_we);
  a_r7_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    restart_cb |=> (!restart_cb && state == S_IDLE));
  a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    cb_abort |-> (state == S_IDLE && status == SS_EXC));
  a_r3_fbit_fmm: assert property (@(posedge clk) disable iff (!rst_n)
    fault_bit |-> (state == S_FMM || state == S_WRT || state == S_RST));
  a_r4_hwe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HWE) |-> (cause >= 7'd3 && cause <= 7'd8));
  a_r12_active_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (status == SS_ACT) |-> (tlb_we || restart_cb));
  a_r6_write_then_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_cb) |-> ($past(tlb_we) || $past(in_miss)));

endmodule

// File: tb/tlb_fault_handle_test.sv
module tlb_fault_handle_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ctx_id = 4'd9;
  logic        fault_valid = 1'b0;
  logic [6:0]  fault_cause = '0;
  logic [63:0] fault_vaddr = '0;
  logic [23:0] fault_asid = '0;
  logic [11:0] fault_idxway = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_opc = '0;
  logic [40:0] fill_pfn = '0;
  logic [23:0] fill_asid = '0;
  logic [63:0] fill_vaddr = '0;
  logic        fill_dirty = 1'b0;
  logic [4:0]  fill_pagesize = '0;
  logic [1:0]  fill_gaa = '0;
  logic [2:0]  state;
  logic [1:0]  status;
  logic [6:0]  cause;
  logic [63:0] miss_vaddr;
  logic [23:0] miss_asid;
  logic [11:0] miss_idxway;
  logic [3:0]  miss_ctx;
  logic        fault_bit;
  logic [31:0] hdl_word;
  logic        tlb_we;
  logic [11:0] tlb_idxway;
  logic [52:0] tlb_paddr;
  logic [23:0] tlb_asid;
  logic [63:0] tlb_vaddr;
  logic        tlb_dirty;
  logic [4:0]  tlb_pagesize;
  logic [1:0]  tlb_gaa;
  logic        restart_cb;
  logic        cb_abort;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tlb_fault_handle uut (
    .clk(clk), .rst_n(rst_n), .ctx_id(ctx_id),
    .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_vaddr(fault_vaddr),
    .fault_asid(fault_asid), .fault_idxway(fault_idxway),
    .cmd_valid(cmd_valid), .cmd_opc(cmd_opc), .fill_pfn(fill_pfn), .fill_asid(fill_asid),
    .fill_vaddr(fill_vaddr), .fill_dirty(fill_dirty), .fill_pagesize(fill_pagesize),
    .fill_gaa(fill_gaa), .state(state), .status(status), .cause(cause),
    .miss_vaddr(miss_vaddr), .miss_asid(miss_asid), .miss_idxway(miss_idxway),
    .miss_ctx(miss_ctx), .fault_bit(fault_bit), .hdl_word(hdl_word), .tlb_we(tlb_we),
    .tlb_idxway(tlb_idxway), .tlb_paddr(tlb_paddr), .tlb_asid(tlb_asid),
    .tlb_vaddr(tlb_vaddr), .tlb_dirty(tlb_dirty), .tlb_pagesize(tlb_pagesize),
    .tlb_gaa(tlb_gaa), .restart_cb(restart_cb), .cb_abort(cb_abort)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fault(input logic [6:0] c, input logic [63:0] va, input logic [23:0] as, input logic [11:0] ix);
    @(negedge clk);
    fault_valid = 1'b1; fault_cause = c; fault_vaddr = va; fault_asid = as; fault_idxway = ix;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opc = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 state", state, 0); chk("R1 status", status, 0);
    chk("R1 fbit", fault_bit, 0); chk("R1 we", tlb_we, 0);
    chk("R1 restart", restart_cb, 0); chk("R1 abort", cb_abort, 0);
    fault(7'd1, 64'h1234, 24'h1, 12'h1);
    chk("R2 fault ignored while inactive", state, 0);
    cmd(3'd0);
    chk("R1 noop activates", state, 1);
  endtask

  task automatic t_illegal;
    cmd(3'd1);
    chk("R8 restart in idle status", status, 1); chk("R8 restart in idle state", state, 1);
    cmd(3'd0);
    cmd(3'd5);
    chk("R8 opcode 5 status", status, 1);
    cmd(3'd2);
    chk("R8 write-only in idle state", state, 1); chk("R8 no write", tlb_we, 0);
  endtask

  task automatic t_miss_fmm;
    fault(7'd1, 64'hDEAD_BEEF_0000_1000, 24'hABCDEF, 12'h5A3);
    chk("R2 state fmm", state, 3); chk("R2 vaddr", miss_vaddr, 64'hDEAD_BEEF_0000_1000);
    chk("R2 asid", miss_asid, 24'hABCDEF); chk("R2 idx", miss_idxway, 12'h5A3);
    chk("R2 ctx", miss_ctx, 9); chk("R2 cause", cause, 1);
    chk("R3 fault bit set", fault_bit, 1); chk("R2 status", status, 0);
    chk("R10 word", hdl_word, {1'b0, 7'd1, 1'b0, 3'd3, 2'b00, 2'd0, 16'd0});
    fault(7'd2, 64'h7777, 24'h2, 12'h2);
    chk("R2 second fault ignored", miss_vaddr, 64'hDEAD_BEEF_0000_1000);
    chk("R2 second cause ignored", cause, 1);
  endtask

  task automatic t_write_only;
    fill_pfn = 41'h1_2345_6789; fill_asid = 24'h55AA55; fill_vaddr = 64'hCAFE_0000;
    fill_dirty = 1'b1; fill_pagesize = 5'd5; fill_gaa = 2'd1;
    cmd(3'd2);
    chk("R5 we", tlb_we, 1); chk("R5 state", state, 5); chk("R5 status active", status, 2);
    chk("R10 busy bit", hdl_word[0], 1); chk("R10 status field", hdl_word[17:16], 2);
    chk("R11 paddr", tlb_paddr, {41'h1_2345_6789, 12'h000});
    chk("R11 gaa mmio", tlb_gaa, 1); chk("R5 idx", tlb_idxway, 12'h5A3);
    chk("R5 asid", tlb_asid, 24'h55AA55); chk("R5 vaddr", tlb_vaddr, 64'hCAFE_0000);
    chk("R5 dirty", tlb_dirty, 1); chk("R5 pagesize", tlb_pagesize, 5);
    @(negedge clk);
    chk("R5 we drops", tlb_we, 0); chk("R5 back to miss", state, 3);
    chk("R5 status idle", status, 0); chk("R5 restart low", restart_cb, 0);
    chk("R3 bit kept", fault_bit, 1);
  endtask

  task automatic t_write_restart_busy;
    fill_gaa = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opc = 3'd3;
    @(negedge clk);
    chk("R6 write cycle", state, 5); chk("R6 we", tlb_we, 1);
    chk("R11 gaa ncram", tlb_gaa, 2);
    cmd_opc = 3'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 restart cycle", state, 6); chk("R6 restart", restart_cb, 1);
    chk("R6 we low", tlb_we, 0); chk("R12 abort not taken", cb_abort, 0);
    @(negedge clk);
    chk("R6 idle", state, 1); chk("R12 status idle", status, 0);
    chk("R3 bit cleared", fault_bit, 0); chk("R6 restart low", restart_cb, 0);
  endtask

  task automatic t_poll_restart;
    cmd(3'd7);
    chk("R13 poll accepted", status, 0); chk("R13 state", state, 1);
    fault(7'd2, 64'h4000, 24'h3, 12'h7);
    chk("R2 state upm", state, 2); chk("R3 no fault bit", fault_bit, 0);
    chk("R2 cause modify", cause, 2);
    cmd(3'd7);
    chk("R13 poll refused in miss", status, 1);
    cmd(3'd1);
    chk("R7 restart state", state, 6); chk("R7 restart strobe", restart_cb, 1);
    @(negedge clk);
    chk("R7 idle", state, 1); chk("R7 cause cleared", cause, 0);
    chk("R7 strobe low", restart_cb, 0);
  endtask

  task automatic t_hwerr_exc;
    fault(7'd0, 64'h1, 24'h1, 12'h1);
    chk("R4 cause 0 ignored", state, 1);
    fault(7'd9, 64'h1, 24'h1, 12'h1);
    chk("R4 cause 9 ignored", state, 1);
    fault(7'd5, 64'h9000, 24'h4, 12'h8);
    chk("R4 hw state", state, 4); chk("R4 status exc", status, 1); chk("R4 cause", cause, 5);
    cmd(3'd1);
    chk("R8 restart in error state", state, 4);
    cmd(3'd4);
    chk("R9 idle", state, 1); chk("R9 status exc", status, 1); chk("R9 abort", cb_abort, 1);
    @(negedge clk);
    chk("R9 abort single", cb_abort, 0);
    cmd(3'd4);
    chk("R9 exception in idle", status, 1); chk("R9 no abort", cb_abort, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_miss_fmm();
    t_write_only();
    t_write_restart_busy();
    t_poll_restart();
    t_hwerr_exc();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule